// File: doc/BRIEF.md
# Dual-Accumulator Multiply-Accumulate Engine

This block is the arithmetic core of a DSP unit. It takes two 32-bit operands, forms their product, and either adds that product to, subtracts it from, or loads it into one of two 72-bit accumulators. Each accumulator holds a 64-bit product field with 8 guard bits above it. Mode inputs set how the multiply reads its operands: signed or unsigned, and integer or fractional. In fractional mode the product is shifted left by one place so that its binary point sits after bit 63. Other mode inputs decide whether each accumulator saturates, and whether the clamp bound is the narrow 1.63 range or the full 72-bit range.

A new operation is offered by raising `inValid` for one cycle with the operands, the accumulator select and the operation code. The mode inputs are sampled on that same rising edge. The result appears on the accumulator outputs after that edge. Sticky flags for each accumulator record when a result fell outside the 1.63 range, when it fell outside the 72-bit range, and when a clamp was applied. Only reset clears these flags.

Top module: `dualacc_mac`

## Requirements
- R1: After reset, both accumulators read zero and every bit of `ovfNarrow`, `ovfWide` and `satFlag` is zero.
- R2: With `modeUnsigned`=0 the operands are treated as two's-complement values. With `modeUnsigned`=1 they are treated as unsigned. The product is sign-extended (signed mode) or zero-extended (unsigned mode) to 72 bits.
- R3: With `modeInteger`=1 the product is used unshifted. With `modeInteger`=0 (fractional) the product is shifted left by one bit before it is accumulated.
- R4: In signed fractional mode, the product of 0x80000000 with itself becomes 2^63-1 (0x00_7FFF_FFFF_FFFF_FFFF) instead of 2^63.
- R5: `opCode` 2'b00 adds the product to the selected accumulator, 2'b01 subtracts it, and 2'b10 loads the product. 2'b11 leaves both accumulators and all flags unchanged. Nothing changes while `inValid` is 0. An accepted operation is visible on the outputs after the rising edge that samples `inValid`.
- R6: `accSel`=0 selects accumulator A and `accSel`=1 selects accumulator B. The accumulator that is not selected keeps its value.
- R7: With saturation disabled for the selected accumulator, the result wraps modulo 2^72.
- R8: Bit i of `ovfNarrow` (bit 0 for A, bit 1 for B) is set when an exact result written to accumulator i lies outside [-2^63, 2^63-1]. The bit stays set until reset.
- R9: Bit i of `ovfWide` is set when an exact result for accumulator i lies outside [-2^71, 2^71-1]. The bit stays set until reset.
- R10: When `satEn[i]`=1 and `satSuper`=0, a result outside the 1.63 range is replaced by 0x00_7FFF_FFFF_FFFF_FFFF or 0xFF_8000_0000_0000_0000, chosen by the sign of the exact result.
- R11: When `satEn[i]`=1 and `satSuper`=1, a result outside the 72-bit range is replaced by 0x7F_FFFF_FFFF_FFFF_FFFF or 0x80_0000_0000_0000_0000. Results inside that range are written as they are, even when they lie outside the 1.63 range.
- R12: Bit i of `satFlag` is set only when a clamp replaced the result for accumulator i. The bit stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operation strobe |
| accSel | input | 1 | Target accumulator: 0 = A, 1 = B |
| opCode | input | 2 | 00 add, 01 subtract, 10 load, 11 no-op |
| opA | input | 32 | First multiplier operand |
| opB | input | 32 | Second multiplier operand |
| modeUnsigned | input | 1 | 1 = unsigned operands, 0 = signed |
| modeInteger | input | 1 | 1 = integer product, 0 = fractional (shift left by one) |
| satEn | input | 2 | Saturation enable: bit 0 for A, bit 1 for B |
| satSuper | input | 1 | Clamp bound: 0 = 1.63 range, 1 = full 72-bit range |
| accA | output | 72 | Accumulator A |
| accB | output | 72 | Accumulator B |
| ovfNarrow | output | 2 | Sticky flag: a result left the 1.63 range |
| ovfWide | output | 2 | Sticky flag: a result left the 72-bit range |
| satFlag | output | 2 | Sticky flag: a clamp was applied |

## Verification
The vector walk covers these operand patterns:
- small positive and negative integers, which separate add from subtract from load and signed from unsigned extension;
- all-ones operands in both signedness modes, which shows whether the upper half of the product is sign-extended or zero-extended;
- half-scale and most-negative fractional operands, which confirm the one-bit alignment shift and the special case for the most negative value squared;
- chains of subtractions that push past the negative 1.63 limit, which separate the positive clamp value from the negative one.

A long run of 2^63 additions into both accumulators, one with saturation off and one with the wide bound, compares a wrapped result against a clamped one at exactly 2^71. That run also shows that the wide bound does not clip values beyond the 1.63 range.

// File: rtl/mac_pkg.sv
package mac_pkg;

  localparam int NUM_ACC = 2;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_LOAD = 2'b10,
    OP_NOP  = 2'b11
  } macOp_e;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic [NUM_ACC-1:0] upd;
    logic               subtract;
    logic               load;
  } macStrobe_t;

endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
(
  input  logic       inValid,
  input  logic       accSel,
  input  logic [1:0] opCode,
  output macStrobe_t strobe
);

  macOp_e opKind;

  always_comb begin
    opKind = macOp_e'(opCode);
    strobe = '0;
    if (inValid && opKind != OP_NOP) begin
      strobe.upd[accSel] = 1'b1;
    end
    strobe.subtract = (opKind == OP_SUB);
    strobe.load     = (opKind == OP_LOAD);
  end

endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_pkg::*;
#(
  parameter int OP_W    = 32,
  parameter int GUARD_W = 8
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  macStrobe_t                                strobe,
  input  logic [OP_W-1:0]                           opA,
  input  logic [OP_W-1:0]                           opB,
  input  logic                                      modeUnsigned,
  input  logic                                      modeInteger,
  input  logic [NUM_ACC-1:0]                        satEn,
  input  logic                                      satSuper,
  output logic [NUM_ACC-1:0][2*OP_W+GUARD_W-1:0]    accQ,
  output logic [NUM_ACC-1:0]                        ovfNarrow,
  output logic [NUM_ACC-1:0]                        ovfWide,
  output logic [NUM_ACC-1:0]                        satFlag
);

  localparam int PROD_W = 2 * OP_W;
  localparam int ACC_W  = PROD_W + GUARD_W;
  localparam int EXT_W  = OP_W + 1;
  localparam int MUL_W  = 2 * EXT_W;
  localparam int SUM_W  = ACC_W + 1;

  localparam logic [OP_W-1:0]  OP_MIN   = {1'b1, {(OP_W-1){1'b0}}};
  localparam logic [ACC_W-1:0] NORM_MAX = {{(GUARD_W+1){1'b0}}, {(PROD_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] NORM_MIN = ~NORM_MAX;
  localparam logic [ACC_W-1:0] WIDE_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] WIDE_MIN = ~WIDE_MAX;

  // Operand extension and multiply
  logic signed [EXT_W-1:0] extA, extB;
  logic signed [MUL_W-1:0] mulFull;
  logic [ACC_W-1:0]        prodExt;
  logic [ACC_W-1:0]        prodAligned;
  logic                    minSquare;

  always_comb begin
    extA    = {(modeUnsigned ? 1'b0 : opA[OP_W-1]), opA};
    extB    = {(modeUnsigned ? 1'b0 : opB[OP_W-1]), opB};
    mulFull = extA * extB;
    prodExt = {{(ACC_W-MUL_W){mulFull[MUL_W-1]}}, mulFull};
    minSquare = !modeUnsigned && !modeInteger && (opA == OP_MIN) && (opB == OP_MIN);
    if (minSquare)        prodAligned = NORM_MAX;
    else if (modeInteger) prodAligned = prodExt;
    else                  prodAligned = prodExt << 1;
  end

  // One adder, range check and clamp per accumulator
  for (genvar i = 0; i < NUM_ACC; i++) begin : g_acc
    logic [SUM_W-1:0] accExt, addend, sumX;
    logic [SUM_W-PROD_W:0] headBits;
    logic narrowOut, wideOut, doSat, negRes;
    logic [ACC_W-1:0] clampVal, nextVal;

    always_comb begin
      accExt  = {accQ[i][ACC_W-1], accQ[i]};
      addend  = {prodAligned[ACC_W-1], prodAligned};
      if (strobe.load)          sumX = addend;
      else if (strobe.subtract) sumX = accExt - addend;
      else                      sumX = accExt + addend;
      headBits  = sumX[SUM_W-1:PROD_W-1];
      narrowOut = !((&headBits) || !(|headBits));
      wideOut   = sumX[SUM_W-1] ^ sumX[SUM_W-2];
      negRes    = sumX[SUM_W-1];
      doSat     = satEn[i] && (satSuper ? wideOut : narrowOut);
      if (satSuper) clampVal = negRes ? WIDE_MIN : WIDE_MAX;
      else          clampVal = negRes ? NORM_MIN : NORM_MAX;
      nextVal = doSat ? clampVal : sumX[ACC_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        accQ[i]      <= '0;
        ovfNarrow[i] <= 1'b0;
        ovfWide[i]   <= 1'b0;
        satFlag[i]   <= 1'b0;
      end else if (strobe.upd[i]) begin
        accQ[i]      <= nextVal;
        ovfNarrow[i] <= ovfNarrow[i] | narrowOut;
        ovfWide[i]   <= ovfWide[i] | wideOut;
        satFlag[i]   <= satFlag[i] | doSat;
      end
    end
  end

endmodule

// File: rtl/dualacc_mac.sv
module dualacc_mac
  import mac_pkg::*;
#(
  parameter int OP_W    = 32,
  parameter int GUARD_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      inValid,
  input  logic                      accSel,
  input  logic [1:0]                opCode,
  input  logic [OP_W-1:0]           opA,
  input  logic [OP_W-1:0]           opB,
  input  logic                      modeUnsigned,
  input  logic                      modeInteger,
  input  logic [1:0]                satEn,
  input  logic                      satSuper,
  output logic [2*OP_W+GUARD_W-1:0] accA,
  output logic [2*OP_W+GUARD_W-1:0] accB,
  output logic [1:0]                ovfNarrow,
  output logic [1:0]                ovfWide,
  output logic [1:0]                satFlag
);

  localparam int ACC_W = 2 * OP_W + GUARD_W;

  macStrobe_t strobe;
  logic [NUM_ACC-1:0][ACC_W-1:0] accQ;

  mac_ctrl u_ctrl (
    .inValid (inValid),
    .accSel  (accSel),
    .opCode  (opCode),
    .strobe  (strobe)
  );

  mac_datapath #(.OP_W(OP_W), .GUARD_W(GUARD_W)) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe       (strobe),
    .opA          (opA),
    .opB          (opB),
    .modeUnsigned (modeUnsigned),
    .modeInteger  (modeInteger),
    .satEn        (satEn),
    .satSuper     (satSuper),
    .accQ         (accQ),
    .ovfNarrow    (ovfNarrow),
    .ovfWide      (ovfWide),
    .satFlag      (satFlag)
  );

  assign accA = accQ[0];
  assign accB = accQ[1];

endmodule

// File: rtl/mac_checker.sv
module mac_checker #(
  parameter int ACC_W   = 72,
  parameter int GUARD_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             inValid,
  input logic             accSel,
  input logic [1:0]       opCode,
  input logic [1:0]       satEn,
  input logic             satSuper,
  input logic [ACC_W-1:0] accA,
  input logic [ACC_W-1:0] accB,
  input logic [1:0]       ovfNarrow,
  input logic [1:0]       ovfWide,
  input logic [1:0]       satFlag
);

  localparam int TOP_LO = ACC_W - GUARD_W - 1;

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> (accA == $past(accA) && accB == $past(accB)));

  p_nop_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && opCode == 2'b11) |=> (accA == $past(accA) && accB == $past(accB)));

  p_keep_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && !accSel) |=> accB == $past(accB));

  p_keep_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && accSel) |=> accA == $past(accA));

  p_narrow_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ovfNarrow & $past(ovfNarrow)) == $past(ovfNarrow)));

  p_wide_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ovfWide & $past(ovfWide)) == $past(ovfWide)));

  p_sat_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((satFlag & $past(satFlag)) == $past(satFlag)));

  p_sat_cause_a_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(satFlag[0]) |-> $past(inValid && !accSel && satEn[0]));

  p_sat_cause_b_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(satFlag[1]) |-> $past(inValid && accSel && satEn[1]));

  p_norm_bound_a_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && !accSel && opCode != 2'b11 && satEn[0] && !satSuper)
      |=> ((&accA[ACC_W-1:TOP_LO]) || !(|accA[ACC_W-1:TOP_LO])));

  p_norm_bound_b_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && accSel && opCode != 2'b11 && satEn[1] && !satSuper)
      |=> ((&accB[ACC_W-1:TOP_LO]) || !(|accB[ACC_W-1:TOP_LO])));

endmodule

bind dualacc_mac mac_checker #(.ACC_W(ACC_W), .GUARD_W(GUARD_W)) u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .inValid   (inValid),
  .accSel    (accSel),
  .opCode    (opCode),
  .satEn     (satEn),
  .satSuper  (satSuper),
  .accA      (accA),
  .accB      (accB),
  .ovfNarrow (ovfNarrow),
  .ovfWide   (ovfWide),
  .satFlag   (satFlag)
);

// File: tb/dualacc_mac_bench.sv
`timescale 1ns/1ps
module dualacc_mac_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic        accSel = 1'b0;
  logic [1:0]  opCode = 2'b00;
  logic [31:0] opA = '0, opB = '0;
  logic        modeUnsigned = 1'b0, modeInteger = 1'b0, satSuper = 1'b0;
  logic [1:0]  satEn = 2'b00;
  logic [71:0] accA, accB;
  logic [1:0]  ovfNarrow, ovfWide, satFlag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dualacc_mac u_dualacc_mac (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .accSel(accSel), .opCode(opCode),
    .opA(opA), .opB(opB), .modeUnsigned(modeUnsigned), .modeInteger(modeInteger),
    .satEn(satEn), .satSuper(satSuper), .accA(accA), .accB(accB),
    .ovfNarrow(ovfNarrow), .ovfWide(ovfWide), .satFlag(satFlag)
  );

  typedef struct packed {
    logic        valid;
    logic        sel;
    logic [1:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic        uns;
    logic        integ;
    logic [1:0]  sat;
    logic        sup;
    logic [71:0] expA;
    logic [71:0] expB;
    logic [1:0]  expN;
    logic [1:0]  expW;
    logic [1:0]  expS;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    // 0: R5 load, R3 integer: 3*5
    '{1'b1,1'b0,2'b10,32'd3,32'd5,1'b0,1'b1,2'b00,1'b0, 72'd15, 72'd0, 2'b00,2'b00,2'b00},
    // 1: R2 signed add, -2*7
    '{1'b1,1'b0,2'b00,32'hFFFFFFFE,32'd7,1'b0,1'b1,2'b00,1'b0, 72'd1, 72'd0, 2'b00,2'b00,2'b00},
    // 2: R5 subtract to negative
    '{1'b1,1'b0,2'b01,32'd4,32'd1,1'b0,1'b1,2'b00,1'b0, 72'hFF_FFFF_FFFF_FFFF_FFFD, 72'd0, 2'b00,2'b00,2'b00},
    // 3: R2 unsigned into B, R6 A holds
    '{1'b1,1'b1,2'b10,32'hFFFFFFFF,32'd2,1'b1,1'b1,2'b00,1'b0, 72'hFF_FFFF_FFFF_FFFF_FFFD, 72'h00_0000_0001_FFFF_FFFE, 2'b00,2'b00,2'b00},
    // 4: R2 same operands signed
    '{1'b1,1'b1,2'b10,32'hFFFFFFFF,32'd2,1'b0,1'b1,2'b00,1'b0, 72'hFF_FFFF_FFFF_FFFF_FFFD, 72'hFF_FFFF_FFFF_FFFF_FFFE, 2'b00,2'b00,2'b00},
    // 5: R3 fractional 0.5*0.5
    '{1'b1,1'b0,2'b10,32'h40000000,32'h40000000,1'b0,1'b0,2'b00,1'b0, 72'h00_2000_0000_0000_0000, 72'hFF_FFFF_FFFF_FFFF_FFFE, 2'b00,2'b00,2'b00},
    // 6: R4 min*min clamp
    '{1'b1,1'b0,2'b10,32'h80000000,32'h80000000,1'b0,1'b0,2'b00,1'b0, 72'h00_7FFF_FFFF_FFFF_FFFF, 72'hFF_FFFF_FFFF_FFFF_FFFE, 2'b00,2'b00,2'b00},
    // 7: R8 add beyond 1.63, no saturation
    '{1'b1,1'b0,2'b00,32'h80000000,32'h80000000,1'b0,1'b0,2'b00,1'b0, 72'h00_FFFF_FFFF_FFFF_FFFE, 72'hFF_FFFF_FFFF_FFFF_FFFE, 2'b01,2'b00,2'b00},
    // 8: R2 R3 unsigned fractional load, R8 for B
    '{1'b1,1'b1,2'b10,32'hFFFFFFFF,32'hFFFFFFFF,1'b1,1'b0,2'b00,1'b0, 72'h00_FFFF_FFFF_FFFF_FFFE, 72'h01_FFFF_FFFC_0000_0002, 2'b11,2'b00,2'b00},
    // 9: R10 same load with B normal saturation
    '{1'b1,1'b1,2'b10,32'hFFFFFFFF,32'hFFFFFFFF,1'b1,1'b0,2'b10,1'b0, 72'h00_FFFF_FFFF_FFFF_FFFE, 72'h00_7FFF_FFFF_FFFF_FFFF, 2'b11,2'b00,2'b10},
    // 10: R10 positive clamp on A
    '{1'b1,1'b0,2'b01,32'd1,32'd1,1'b0,1'b1,2'b01,1'b0, 72'h00_7FFF_FFFF_FFFF_FFFF, 72'h00_7FFF_FFFF_FFFF_FFFF, 2'b11,2'b00,2'b11},
    // 11: R5 subtract to zero
    '{1'b1,1'b0,2'b01,32'h80000000,32'h80000000,1'b0,1'b0,2'b01,1'b0, 72'd0, 72'h00_7FFF_FFFF_FFFF_FFFF, 2'b11,2'b00,2'b11},
    // 12: R10 in range negative, no clamp
    '{1'b1,1'b0,2'b01,32'h80000000,32'h80000000,1'b0,1'b0,2'b01,1'b0, 72'hFF_8000_0000_0000_0001, 72'h00_7FFF_FFFF_FFFF_FFFF, 2'b11,2'b00,2'b11},
    // 13: R10 negative clamp
    '{1'b1,1'b0,2'b01,32'h80000000,32'h80000000,1'b0,1'b0,2'b01,1'b0, 72'hFF_8000_0000_0000_0000, 72'h00_7FFF_FFFF_FFFF_FFFF, 2'b11,2'b00,2'b11},
    // 14: R5 no-op code
    '{1'b1,1'b0,2'b11,32'd5,32'd5,1'b0,1'b1,2'b00,1'b0, 72'hFF_8000_0000_0000_0000, 72'h00_7FFF_FFFF_FFFF_FFFF, 2'b11,2'b00,2'b11},
    // 15: R5 strobe low
    '{1'b0,1'b0,2'b00,32'd5,32'd5,1'b0,1'b1,2'b00,1'b0, 72'hFF_8000_0000_0000_0000, 72'h00_7FFF_FFFF_FFFF_FFFF, 2'b11,2'b00,2'b11},
    // 16: R2 signed -1 added to B under saturation, in range
    '{1'b1,1'b1,2'b00,32'hFFFFFFFF,32'd1,1'b0,1'b1,2'b10,1'b0, 72'hFF_8000_0000_0000_0000, 72'h00_7FFF_FFFF_FFFF_FFFE, 2'b11,2'b00,2'b11}
  };

  task automatic chk(input string what, input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic s, input logic [1:0] op,
                       input logic [31:0] a, input logic [31:0] b, input logic u,
                       input logic it, input logic [1:0] se, input logic sp);
    @(negedge clk);
    inValid = v; accSel = s; opCode = op; opA = a; opB = b;
    modeUnsigned = u; modeInteger = it; satEn = se; satSuper = sp;
    @(posedge clk);
    #1;
  endtask

  task automatic doReset();
    @(negedge clk);
    inValid = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    doReset();
    // R1 reset state
    chk("accA after reset", "R1", accA, 72'd0);
    chk("accB after reset", "R1", accB, 72'd0);
    chk("flags after reset", "R1", {66'd0, ovfNarrow, ovfWide, satFlag}, 72'd0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].valid, VECS[i].sel, VECS[i].op, VECS[i].a, VECS[i].b,
            VECS[i].uns, VECS[i].integ, VECS[i].sat, VECS[i].sup);
      chk($sformatf("vec %0d accA", i), "R2-R7,R10 value", accA, VECS[i].expA);
      chk($sformatf("vec %0d accB", i), "R6 value", accB, VECS[i].expB);
      chk($sformatf("vec %0d ovfNarrow", i), "R8", {70'd0, ovfNarrow}, {70'd0, VECS[i].expN});
      chk($sformatf("vec %0d ovfWide", i), "R9", {70'd0, ovfWide}, {70'd0, VECS[i].expW});
      chk($sformatf("vec %0d satFlag", i), "R12", {70'd0, satFlag}, {70'd0, VECS[i].expS});
    end

    // R7 wrap on A against R11 wide clamp on B, adding 2^63 each step
    doReset();
    for (int k = 1; k <= 256; k++) begin
      drive(1'b1, 1'b0, 2'b00, 32'h80000000, 32'h80000000, 1'b1, 1'b0, 2'b00, 1'b0);
      drive(1'b1, 1'b1, 2'b00, 32'h80000000, 32'h80000000, 1'b1, 1'b0, 2'b10, 1'b1);
      if (k == 1) begin
        chk("B past 1.63 kept under wide bound", "R11", accB, 72'h00_8000_0000_0000_0000);
        chk("narrow flag set for B", "R8", {70'd0, ovfNarrow}, 72'd3);
        chk("no clamp yet", "R12", {70'd0, satFlag}, 72'd0);
      end
      if (k == 255) begin
        chk("A at 255 steps", "R7", accA, 72'h7F_8000_0000_0000_0000);
        chk("B at 255 steps", "R11", accB, 72'h7F_8000_0000_0000_0000);
        chk("wide flags clear", "R9", {70'd0, ovfWide}, 72'd0);
      end
    end
    chk("A wraps at 2^71", "R7", accA, 72'h80_0000_0000_0000_0000);
    chk("B clamps at wide max", "R11", accB, 72'h7F_FFFF_FFFF_FFFF_FFFF);
    chk("wide flags both set", "R9", {70'd0, ovfWide}, 72'd3);
    chk("only B clamped", "R12", {70'd0, satFlag}, 72'd2);

    // R1 reset clears sticky state
    doReset();
    chk("accA cleared", "R1", accA, 72'd0);
    chk("flags cleared", "R1", {66'd0, ovfNarrow, ovfWide, satFlag}, 72'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule